// File: doc/BRIEF.md
# Predicated Vector Element Iterator

This block sequences the element loop of a predicated vector operation. A start pulse captures the vector length, the sub-vector length code and the predicate selection. From then on the block issues one strobe per clock cycle. Each strobe carries an element index, a sub-element index and a paired source index. Elements whose predicate bit is clear are skipped and cost no cycles. Operand fetch and execution sit downstream, and this block only tells them which element and sub-element to handle next.

A predicate is either integer-based or condition-field-based, chosen by a mode bit. A 3-bit code then picks the source and the test. Integer codes select all-enabled, one-hot-by-register, or a bit test (set or clear) against one of three register values. Condition codes test one of the four flags of the condition field that belongs to each element, for set or clear. With twin predication enabled, a second 3-bit code builds an independent source predicate. Source and destination indices then advance separately, each skipping to its own next enabled element. All register and condition-field values arrive on input ports and are sampled once, at start.

Top module: `pred_elem_iter`

## Requirements
- R1: With mode 0 and code 000, every element 0..VL-1 is enabled. The strobe sequence is identical to mode 0, code 010 with an all-ones first register.
- R2: With mode 0 and code 001, only the element whose index equals the value of `reg_a` is enabled. If `reg_a` is VL or more, nothing is issued.
- R3: With mode 0, codes 010/011 enable element i when bit i of `reg_a` is set/clear. Codes 100/101 do the same on `reg_b`, and codes 110/111 do the same on `reg_c`.
- R4: With mode 1, element i tests nibble i of `cr_win`, which holds condition field 32+i. Within the nibble, bit 3 is LT, bit 2 is GT, bit 1 is EQ and bit 0 is SO/unordered. Codes 000/001 test LT set/clear, 010/011 test GT, 100/101 test EQ and 110/111 test SO.
- R5: A sub-vector code s (00..11) makes each issued element appear for s+1 consecutive cycles, with sub index 0..s in order and unchanged element indices.
- R6: With VL=0, no strobe is issued and `done` is high in the first cycle after the start edge.
- R7: Strobes start in the first cycle after the start edge. They follow back to back with no idle cycles, and destination indices strictly ascend and stay below VL.
- R8: With twin predication enabled, pairs are issued from the next enabled destination and the next enabled source. The run ends as soon as either side has no enabled element left below VL.
- R9: With twin predication disabled, the source index of every strobe equals its destination index.
- R10: Register and condition-field inputs are sampled at the start edge. Changes made during the run have no effect on the strobes.
- R11: `done` is a single-cycle pulse in the cycle after the last strobe. `busy` is high from the cycle after start through the `done` cycle and low afterwards. A start is accepted only while `busy` is low.
- R12: After reset, `busy`, `issue_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run, capturing all other inputs |
| vl | input | VLW (7) | Vector length, 0..MAX_VL |
| subvl | input | 2 | Sub-vector code, length = code+1 |
| mask_kind | input | 1 | 0 integer predication, 1 condition-field predication |
| dst_code | input | 3 | Destination predicate code |
| twin_en | input | 1 | Use a separate source predicate |
| src_code | input | 3 | Source predicate code (same mode as destination) |
| reg_a | input | XLEN (64) | First predicate register value |
| reg_b | input | XLEN (64) | Second predicate register value |
| reg_c | input | XLEN (64) | Third predicate register value |
| cr_win | input | 4*MAX_VL (256) | Condition fields 32.. as nibbles, LT at bit 3 |
| busy | output | 1 | Run in progress |
| issue_valid | output | 1 | Element strobe |
| issue_dst | output | IDXW (6) | Destination element index |
| issue_src | output | IDXW (6) | Source element index |
| issue_sub | output | 2 | Sub-element index |
| done | output | 1 | End-of-run pulse |

## Verification
On every cycle, the assertions check the structural rules of the sequence. Indices stay below the captured VL and sub indices stay within the captured code. A sub-element run holds its element index steady. Destination indices ascend across elements, source equals destination without twin predication, `done` stays a lone pulse that never overlaps a strobe, and a zero-length start yields `done` at once. Only the bench scenarios can show which elements each predicate code selects and that twin runs stop on the shorter side. They also show that late register changes are ignored, and that the total cycle count from start to `done` matches the number of strobes.

// File: rtl/pred_iter_pkg.sv
// Shared types and helpers for the predicated element iterator.
// Assumes condition fields are 4-bit nibbles with LT in the top bit.
package pred_iter_pkg;

    typedef enum logic {
        IT_IDLE = 1'b0,
        IT_RUN  = 1'b1
    } iter_state_t;

    // Bit position within a condition nibble for a flag selector (LT=3 .. SO=0)
    function automatic logic [1:0] cr_flag_pos(input logic [1:0] sel);
        return 2'd3 - sel;
    endfunction

endpackage

// File: rtl/pred_mask_gen.sv
// Expands a 3-bit predicate code under a mode bit into a per-element
// enable vector. Assumes element i of an integer test uses register bit i
// and element i of a condition test uses nibble i of the window.
module pred_mask_gen #(
    parameter int MAX_VL = 64,
    parameter int XLEN   = 64
) (
    input  logic                  kind,
    input  logic [2:0]            code,
    input  logic [XLEN-1:0]       reg_a,
    input  logic [XLEN-1:0]       reg_b,
    input  logic [XLEN-1:0]       reg_c,
    input  logic [4*MAX_VL-1:0]   cr_win,
    output logic [MAX_VL-1:0]     mask
);
    import pred_iter_pkg::*;

    for (genvar i = 0; i < MAX_VL; i++) begin : g_el
        logic       a_bit, b_bit, c_bit, a_hit;
        logic [3:0] nib;

        if (i < XLEN) begin : g_in
            assign a_bit = reg_a[i];
            assign b_bit = reg_b[i];
            assign c_bit = reg_c[i];
        end else begin : g_out
            assign a_bit = 1'b0;
            assign b_bit = 1'b0;
            assign c_bit = 1'b0;
        end

        assign a_hit = (reg_a == XLEN'(i));
        assign nib   = cr_win[4*i +: 4];

        // Decode one element's enable from the code
        always_comb begin
            if (kind) begin
                mask[i] = nib[cr_flag_pos(code[2:1])] ^ code[0];
            end else begin
                case (code)
                    3'b000:  mask[i] = 1'b1;
                    3'b001:  mask[i] = a_hit;
                    3'b010:  mask[i] = a_bit;
                    3'b011:  mask[i] = ~a_bit;
                    3'b100:  mask[i] = b_bit;
                    3'b101:  mask[i] = ~b_bit;
                    3'b110:  mask[i] = c_bit;
                    default: mask[i] = ~c_bit;
                endcase
            end
        end
    end

endmodule

// File: rtl/elem_finder.sv
// Finds the lowest set mask bit at or above a start pointer and below a limit.
// Assumes start and limit are in 0..MAX_VL.
module elem_finder #(
    parameter int MAX_VL = 64,
    parameter int VLW    = $clog2(MAX_VL + 1),
    parameter int IDXW   = $clog2(MAX_VL)
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [VLW-1:0]    from,
    input  logic [VLW-1:0]    lim,
    output logic              found,
    output logic [IDXW-1:0]   idx
);
    // Priority scan from the top so the lowest qualifying index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MAX_VL - 1; i >= 0; i--) begin
            if (mask[i] && (VLW'(i) >= from) && (VLW'(i) < lim)) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/pred_elem_iter.sv
// Predicated vector element iterator. Captures VL, sub-vector code and
// destination/source predicates on start. It then issues one strobe per cycle
// over enabled element pairs and their sub-elements, and pulses done one
// cycle after the last strobe. Assumes start is ignored while busy.
module pred_elem_iter #(
    parameter int MAX_VL = 64,
    parameter int XLEN   = 64,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IDXW  = $clog2(MAX_VL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VLW-1:0]      vl,
    input  logic [1:0]          subvl,
    input  logic                mask_kind,
    input  logic [2:0]          dst_code,
    input  logic                twin_en,
    input  logic [2:0]          src_code,
    input  logic [XLEN-1:0]     reg_a,
    input  logic [XLEN-1:0]     reg_b,
    input  logic [XLEN-1:0]     reg_c,
    input  logic [4*MAX_VL-1:0] cr_win,
    output logic                busy,
    output logic                issue_valid,
    output logic [IDXW-1:0]     issue_dst,
    output logic [IDXW-1:0]     issue_src,
    output logic [1:0]          issue_sub,
    output logic                done
);
    import pred_iter_pkg::*;

    iter_state_t       state_q;
    logic [VLW-1:0]    vl_q, dptr_q, sptr_q;
    logic [1:0]        sub_q, sub_max_q;
    logic [MAX_VL-1:0] dmask_q, smask_q;
    logic [MAX_VL-1:0] dmask_new, smask_new;
    logic              d_found, s_found, pair_ok;
    logic [IDXW-1:0]   d_idx, s_idx;

    pred_mask_gen #(.MAX_VL(MAX_VL), .XLEN(XLEN)) u_dst_gen (
        .kind(mask_kind), .code(dst_code),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .cr_win(cr_win),
        .mask(dmask_new)
    );

    pred_mask_gen #(.MAX_VL(MAX_VL), .XLEN(XLEN)) u_src_gen (
        .kind(mask_kind), .code(src_code),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .cr_win(cr_win),
        .mask(smask_new)
    );

    elem_finder #(.MAX_VL(MAX_VL), .VLW(VLW), .IDXW(IDXW)) u_dst_find (
        .mask(dmask_q), .from(dptr_q), .lim(vl_q), .found(d_found), .idx(d_idx)
    );

    elem_finder #(.MAX_VL(MAX_VL), .VLW(VLW), .IDXW(IDXW)) u_src_find (
        .mask(smask_q), .from(sptr_q), .lim(vl_q), .found(s_found), .idx(s_idx)
    );

    // Strobe and completion outputs derived from the current run state
    always_comb begin
        pair_ok     = (state_q == IT_RUN) && d_found && s_found;
        busy        = (state_q == IT_RUN);
        issue_valid = pair_ok;
        issue_dst   = d_idx;
        issue_src   = s_idx;
        issue_sub   = sub_q;
        done        = (state_q == IT_RUN) && !pair_ok;
    end

    // Run control: capture on start, step sub-elements, then advance pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= IT_IDLE;
            vl_q      <= '0;
            dptr_q    <= '0;
            sptr_q    <= '0;
            sub_q     <= '0;
            sub_max_q <= '0;
            dmask_q   <= '0;
            smask_q   <= '0;
        end else begin
            case (state_q)
                IT_IDLE: begin
                    if (start) begin
                        state_q   <= IT_RUN;
                        vl_q      <= vl;
                        sub_max_q <= subvl;
                        dmask_q   <= dmask_new;
                        smask_q   <= twin_en ? smask_new : dmask_new;
                        dptr_q    <= '0;
                        sptr_q    <= '0;
                        sub_q     <= '0;
                    end
                end
                default: begin
                    if (pair_ok) begin
                        if (sub_q == sub_max_q) begin
                            sub_q  <= '0;
                            dptr_q <= VLW'(d_idx) + VLW'(1);
                            sptr_q <= VLW'(s_idx) + VLW'(1);
                        end else begin
                            sub_q <= sub_q + 2'd1;
                        end
                    end else begin
                        state_q <= IT_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pred_elem_iter_chk.sv
// Protocol checker for the element iterator, bound to every instance.
// Keeps its own copy of the run parameters captured at an accepted start.
module pred_elem_iter_chk #(
    parameter int MAX_VL = 64,
    parameter int VLW    = $clog2(MAX_VL + 1),
    parameter int IDXW   = $clog2(MAX_VL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VLW-1:0]  vl,
    input logic [1:0]      subvl,
    input logic            twin_en,
    input logic            busy,
    input logic            issue_valid,
    input logic [IDXW-1:0] issue_dst,
    input logic [IDXW-1:0] issue_src,
    input logic [1:0]      issue_sub,
    input logic            done
);
    logic [VLW-1:0] cap_vl;
    logic [1:0]     cap_sub;
    logic           cap_twin;

    // Record run parameters seen at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vl   <= '0;
            cap_sub  <= '0;
            cap_twin <= 1'b0;
        end else if (start && !busy) begin
            cap_vl   <= vl;
            cap_sub  <= subvl;
            cap_twin <= twin_en;
        end
    end

    // R7
    dst_below_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (VLW'(issue_dst) < cap_vl));

    // R7
    dst_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_sub == 2'd0 && $past(issue_valid)) |-> (issue_dst > $past(issue_dst)));

    // R5
    sub_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (issue_sub <= cap_sub));

    // R5
    sub_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_sub != 2'd0) |->
            ($past(issue_valid) && issue_dst == $past(issue_dst)
             && issue_sub == 2'($past(issue_sub) + 2'd1)));

    // R9
    single_pred_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !cap_twin) |-> (issue_src == issue_dst));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!issue_valid && busy));

    // R6
    zero_vl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl == '0) |=> (done && !issue_valid));

endmodule

bind pred_elem_iter pred_elem_iter_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl(subvl),
    .twin_en(twin_en), .busy(busy), .issue_valid(issue_valid),
    .issue_dst(issue_dst), .issue_src(issue_src), .issue_sub(issue_sub),
    .done(done)
);

// File: tb/sim_pred_elem_iter.sv
`timescale 1ns/1ps
module sim_pred_elem_iter;
    localparam int MAX_VL = 64;
    localparam int XLEN   = 64;
    localparam int VLW    = $clog2(MAX_VL + 1);
    localparam int IDXW   = $clog2(MAX_VL);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [VLW-1:0]      vl = '0;
    logic [1:0]          subvl = '0;
    logic                mask_kind = 1'b0;
    logic [2:0]          dst_code = '0;
    logic                twin_en = 1'b0;
    logic [2:0]          src_code = '0;
    logic [XLEN-1:0]     reg_a = '0, reg_b = '0, reg_c = '0;
    logic [4*MAX_VL-1:0] cr_win = '0;
    logic                busy, issue_valid, done;
    logic [IDXW-1:0]     issue_dst, issue_src;
    logic [1:0]          issue_sub;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "";
    logic [2*IDXW+1:0] exp_q[$];

    always #2 clk = ~clk;

    pred_elem_iter #(.MAX_VL(MAX_VL), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl(subvl),
        .mask_kind(mask_kind), .dst_code(dst_code), .twin_en(twin_en),
        .src_code(src_code), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .cr_win(cr_win), .busy(busy), .issue_valid(issue_valid),
        .issue_dst(issue_dst), .issue_src(issue_src), .issue_sub(issue_sub),
        .done(done)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %0d expected %0d", req, cur_tag, act, exp);
        end
    endtask

    // Reference predicate from the requirement text
    function automatic bit ref_en(input bit kind, input bit [2:0] code, input int i,
                                  input logic [63:0] a, input logic [63:0] b,
                                  input logic [63:0] c, input logic [4*MAX_VL-1:0] cr);
        logic [3:0] nib;
        bit f;
        if (!kind) begin
            case (code)
                3'd0: return 1'b1;
                3'd1: return a == 64'(i);
                3'd2: return a[i];
                3'd3: return !a[i];
                3'd4: return b[i];
                3'd5: return !b[i];
                3'd6: return c[i];
                default: return !c[i];
            endcase
        end
        nib = cr[4*i +: 4];
        case (code[2:1])
            2'd0: f = nib[3];
            2'd1: f = nib[2];
            2'd2: f = nib[1];
            default: f = nib[0];
        endcase
        return code[0] ? !f : f;
    endfunction

    // Monitor: pop and compare each strobe away from the clock edge
    always @(negedge clk) begin
        if (rst_n && issue_valid) begin
            if (exp_q.size() == 0) begin
                check("R7", 1'b0, issue_dst, -1);
            end else begin
                logic [2*IDXW+1:0] e;
                e = exp_q.pop_front();
                check("R5 issue", {issue_dst, issue_src, issue_sub} == e,
                      {issue_dst, issue_src, issue_sub}, e);
            end
        end
    end

    // Driver: compute expected strobes, push them, start the run, time done
    task automatic run_case(input string tag, input bit kind, input bit [2:0] dc,
                            input bit tw, input bit [2:0] sc, input int n,
                            input bit [1:0] sv, input logic [63:0] a,
                            input logic [63:0] b, input logic [63:0] c,
                            input logic [4*MAX_VL-1:0] cr, input bit scramble);
        int d = 0, s = 0, nexp = 0, cyc = 0;
        @(negedge clk);
        cur_tag = tag;
        vl = VLW'(n); subvl = sv; mask_kind = kind; dst_code = dc;
        twin_en = tw; src_code = sc; reg_a = a; reg_b = b; reg_c = c; cr_win = cr;
        forever begin
            while (d < n && !ref_en(kind, dc, d, a, b, c, cr)) d++;
            while (s < n && !ref_en(kind, tw ? sc : dc, s, a, b, c, cr)) s++;
            if (d >= n || s >= n) break;
            for (int k = 0; k <= int'(sv); k++) begin
                exp_q.push_back({IDXW'(d), IDXW'(s), 2'(k)});
                nexp++;
            end
            d++; s++;
        end
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        if (scramble) begin
            reg_a = ~a; reg_b = ~b; reg_c = ~c; cr_win = ~cr;
        end
        forever begin
            @(negedge clk);
            cyc++;
            if (done || cyc > 1000) break;
        end
        check("R11 done latency", cyc == nexp + 1, cyc, nexp + 1);
        check("R7 all strobes seen", exp_q.size() == 0, exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check("R11 done single", done == 1'b0, done, 0);
        check("R11 busy cleared", busy == 1'b0, busy, 0);
    endtask

    initial begin
        logic [4*MAX_VL-1:0] crv;
        for (int j = 0; j < MAX_VL; j++) crv[4*j +: 4] = 4'((j * 7 + 3) % 16);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "reset";
        check("R12 busy", busy == 1'b0, busy, 0);
        check("R12 issue_valid", issue_valid == 1'b0, issue_valid, 0);
        check("R12 done", done == 1'b0, done, 0);

        run_case("R1 all", 0, 3'b000, 0, 0, 7, 2'd0, 64'h0, 64'h0, 64'h0, '0, 0);
        run_case("R1 ones", 0, 3'b010, 0, 0, 7, 2'd0, '1, 64'h0, 64'h0, '0, 0);
        run_case("R2 onehot", 0, 3'b001, 0, 0, 8, 2'd2, 64'd3, 64'h0, 64'h0, '0, 0);
        run_case("R2 beyond", 0, 3'b001, 0, 0, 8, 2'd0, 64'd9, 64'h0, 64'h0, '0, 0);
        run_case("R3 notA", 0, 3'b011, 0, 0, 12, 2'd1, 64'h0A5, 64'h0, 64'h0, '0, 0);
        run_case("R3 B", 0, 3'b100, 0, 0, 16, 2'd0, 64'h0, 64'hC3_21, 64'h0, '0, 0);
        run_case("R3 notC", 0, 3'b111, 0, 0, 10, 2'd0, 64'h0, 64'h0, 64'h2F0, '0, 0);
        run_case("R4 LT", 1, 3'b000, 0, 0, 20, 2'd0, 64'h0, 64'h0, 64'h0, crv, 0);
        run_case("R4 GT clr", 1, 3'b011, 0, 0, 20, 2'd1, 64'h0, 64'h0, 64'h0, crv, 0);
        run_case("R4 EQ", 1, 3'b100, 0, 0, 33, 2'd0, 64'h0, 64'h0, 64'h0, crv, 0);
        run_case("R4 SO clr", 1, 3'b111, 0, 0, 33, 2'd0, 64'h0, 64'h0, 64'h0, crv, 0);
        run_case("R6 vl0", 0, 3'b000, 0, 0, 0, 2'd3, 64'h0, 64'h0, 64'h0, '0, 0);
        run_case("R8 twin", 0, 3'b100, 1, 3'b111, 8, 2'd0, 64'h0, 64'hB5, 64'h0C, '0, 0);
        run_case("R8 twin cr", 1, 3'b010, 1, 3'b101, 24, 2'd1, 64'h0, 64'h0, 64'h0, crv, 0);
        run_case("R9 single", 0, 3'b010, 0, 3'b111, 16, 2'd0, 64'h9C3, 64'h0, 64'h0, '0, 0);
        run_case("R10 scramble", 0, 3'b010, 0, 0, 16, 2'd0, 64'h5A5A, 64'h0, 64'h0, '0, 1);
        run_case("R10 scramble cr", 1, 3'b100, 0, 0, 16, 2'd0, 64'h0, 64'h0, 64'h0, crv, 1);
        run_case("R5 full", 0, 3'b000, 0, 0, MAX_VL, 2'd3, 64'h0, 64'h0, 64'h0, '0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(200000 * 4);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog [%s]: actual timeout expected finish", cur_tag);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule